// File: doc/BRIEF.md
# Track Format Byte Sequencer

This block produces the complete byte stream needed to lay down one freshly formatted track on a floppy medium, in either single-density (FM) or double-density (MFM) form. After a start strobe it walks through the opening gap, a sync run, the index address mark and the first gap. It then repeats a sector section once per requested sector: an ID field carrying cylinder, head, record and size code with its CRC, a second gap, and a data field filled with one repeated byte, closed by its own CRC and a programmable inter-sector gap. After the last sector it pads the rest of the track with gap fill until a stop or index strobe ends it.

Each byte leaves through a valid/ready handshake. A side flag marks the bytes that a downstream bit encoder must write with a missing-clock pattern. The formatting parameters are sampled when the track starts. The record number written into each ID field counts up from the supplied starting value.

Top module: `trk_fmt_seq`

## Requirements
- R1: During and straight after reset, busy and out_valid are low.
- R2: A start pulse while idle samples every setting and raises busy and out_valid on the next cycle, with the first byte already presented. A start pulse before the closing gap has no effect on the stream.
- R3: In FM mode the track opens with 40 bytes FF, 6 bytes 00, the index mark FC and 26 bytes FF.
- R4: In MFM mode the track opens with 80 bytes 4E, 12 bytes 00, three C2 bytes, the index mark FC and 50 bytes 4E.
- R5: Each sector's ID section is a sync run of 00 (6 in FM, 12 in MFM), three A1 bytes in MFM only, mark FE, then cylinder, head, record and size code, two CRC bytes, and a gap of 11 FF (FM) or 22 4E (MFM).
- R6: Each data section is the same sync run and MFM prefix as the ID section. It is followed by mark F8 when del_data is 1 or FB otherwise, then 128·2^size_code copies of fill_byte, two CRC bytes, and gap3_len gap bytes (FF in FM, 4E in MFM; a length of 0 stands for 256).
- R7: Both CRCs use polynomial 0x1021 with preset FFFF. Each covers the MFM A1 prefix bytes (if any), the mark byte and the field bytes, and is sent high byte first.
- R8: out_mark is 1 on the C2 and A1 prefix bytes in MFM, and on the FC, FE, FB and F8 mark bytes in FM. It is 0 on every other byte.
- R9: A byte is consumed only on a cycle with out_valid and out_ready high. While out_ready is low, out_data and out_mark hold.
- R10: With a sector count of 0, the gap after the index mark is followed directly by the closing gap.
- R11: After the last sector, the closing gap emits mode fill bytes for as long as the sink takes them. A start or stop pulse during it ends the track, so busy is low from the next cycle on, even when a byte is taken in the same cycle.
- R12: The record byte of sector k (counting from 0) is id_rec + k modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a track when idle; ends it during the closing gap |
| stop | input | 1 | Ends the track during the closing gap |
| mfm_sel | input | 1 | 1 = MFM layout, 0 = FM layout |
| del_data | input | 1 | 1 = deleted-data mark F8, 0 = normal mark FB |
| sec_total | input | 8 | Number of sectors on the track |
| size_code | input | 3 | Sector size code N; data length 128·2^N |
| gap3_len | input | 8 | Gap after each data field (0 = 256) |
| fill_byte | input | 8 | Value of every data byte |
| id_cyl | input | 8 | Cylinder byte for the ID fields |
| id_head | input | 8 | Head byte for the ID fields |
| id_rec | input | 8 | Record number of the first sector |
| out_data | output | 8 | Byte presented to the encoder |
| out_valid | output | 1 | out_data is meaningful |
| out_ready | input | 1 | Sink accepts the presented byte |
| out_mark | output | 1 | Byte needs the missing-clock pattern |
| busy | output | 1 | A track is in progress |

## Verification
The bench targets the section boundaries where a length is off by one: the sync and gap runs of both modes, a zero sector count that skips the sector loop, and a GAP3 length of 0 that has to mean 256. A design that got any of these wrong would shift every later byte and break the byte-by-byte comparison. CRCs are recomputed in the bench, so a wrong preset, a missing A1 in the coverage or swapped byte order shows up as CRC mismatches. The bench also checks record numbers wrapping past FF, stalls of the sink while a byte is presented, a start pulse in mid-track that a faulty design would take as a restart, and a track end that arrives together with a byte transfer.

// File: rtl/trk_fmt_pkg.sv
package trk_fmt_pkg;

    localparam int SZ_W  = 3;
    localparam int CNT_W = 7 + (2 ** SZ_W);

    typedef enum logic [4:0] {
        SG_IDLE,
        SG_PRE_GAP,
        SG_IX_SYNC,
        SG_IX_PFX,
        SG_IX_MARK,
        SG_POST_IX,
        SG_ID_SYNC,
        SG_ID_PFX,
        SG_ID_MARK,
        SG_ID_BODY,
        SG_ID_CRC,
        SG_ID_GAP,
        SG_DT_SYNC,
        SG_DT_PFX,
        SG_DT_MARK,
        SG_DT_BODY,
        SG_DT_CRC,
        SG_DT_GAP,
        SG_TAIL
    } seg_e;

    typedef struct packed {
        logic            mfm;
        logic            del;
        logic [7:0]      nsec;
        logic [SZ_W-1:0] size;
        logic [7:0]      gap3;
        logic [7:0]      fill;
        logic [7:0]      cyl;
        logic [7:0]      head;
        logic [7:0]      rec;
    } trk_cfg_t;

    function automatic logic [CNT_W-1:0] seg_len(seg_e s, logic mfm,
                                                 logic [SZ_W-1:0] size,
                                                 logic [7:0] gap3);
        logic [CNT_W-1:0] n;
        case (s)
            SG_PRE_GAP: n = mfm ? CNT_W'(80) : CNT_W'(40);
            SG_IX_SYNC,
            SG_ID_SYNC,
            SG_DT_SYNC: n = mfm ? CNT_W'(12) : CNT_W'(6);
            SG_IX_PFX,
            SG_ID_PFX,
            SG_DT_PFX:  n = CNT_W'(3);
            SG_POST_IX: n = mfm ? CNT_W'(50) : CNT_W'(26);
            SG_ID_BODY: n = CNT_W'(4);
            SG_ID_CRC,
            SG_DT_CRC:  n = CNT_W'(2);
            SG_ID_GAP:  n = mfm ? CNT_W'(22) : CNT_W'(11);
            SG_DT_BODY: n = CNT_W'(128) << size;
            SG_DT_GAP:  n = (gap3 == 8'd0) ? CNT_W'(256) : CNT_W'(gap3);
            default:    n = CNT_W'(1);
        endcase
        return n;
    endfunction

    function automatic logic [7:0] gap_byte(logic mfm);
        return mfm ? 8'h4E : 8'hFF;
    endfunction

    function automatic logic [15:0] crc_step(logic [15:0] crc, logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

endpackage

// File: rtl/trk_fmt_ctrl.sv
module trk_fmt_ctrl
    import trk_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             xfer,
    input  trk_cfg_t         cfg_in,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       sec_idx,
    output trk_cfg_t         cfg
);

    logic [CNT_W-1:0] len;
    logic             seg_done;
    logic             last_sec;
    seg_e             nxt;

    assign len      = seg_len(seg, cfg.mfm, cfg.size, cfg.gap3);
    assign seg_done = (cnt == len - CNT_W'(1));
    assign last_sec = ((sec_idx + 8'd1) == cfg.nsec);

    always_comb begin
        case (seg)
            SG_PRE_GAP: nxt = SG_IX_SYNC;
            SG_IX_SYNC: nxt = cfg.mfm ? SG_IX_PFX : SG_IX_MARK;
            SG_IX_PFX:  nxt = SG_IX_MARK;
            SG_IX_MARK: nxt = SG_POST_IX;
            SG_POST_IX: nxt = (cfg.nsec == 8'd0) ? SG_TAIL : SG_ID_SYNC;
            SG_ID_SYNC: nxt = cfg.mfm ? SG_ID_PFX : SG_ID_MARK;
            SG_ID_PFX:  nxt = SG_ID_MARK;
            SG_ID_MARK: nxt = SG_ID_BODY;
            SG_ID_BODY: nxt = SG_ID_CRC;
            SG_ID_CRC:  nxt = SG_ID_GAP;
            SG_ID_GAP:  nxt = SG_DT_SYNC;
            SG_DT_SYNC: nxt = cfg.mfm ? SG_DT_PFX : SG_DT_MARK;
            SG_DT_PFX:  nxt = SG_DT_MARK;
            SG_DT_MARK: nxt = SG_DT_BODY;
            SG_DT_BODY: nxt = SG_DT_CRC;
            SG_DT_CRC:  nxt = SG_DT_GAP;
            SG_DT_GAP:  nxt = last_sec ? SG_TAIL : SG_ID_SYNC;
            default:    nxt = seg;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg     <= SG_IDLE;
            cnt     <= '0;
            sec_idx <= '0;
            cfg     <= '0;
        end else if (seg == SG_IDLE) begin
            if (start) begin
                seg     <= SG_PRE_GAP;
                cnt     <= '0;
                sec_idx <= '0;
                cfg     <= cfg_in;
            end
        end else if (seg == SG_TAIL) begin
            if (start || stop) seg <= SG_IDLE;
        end else if (xfer) begin
            if (seg_done) begin
                seg <= nxt;
                cnt <= '0;
                if (seg == SG_DT_GAP) sec_idx <= sec_idx + 8'd1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/trk_fmt_crc.sv
module trk_fmt_crc
    import trk_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer,
    input  seg_e        seg,
    input  logic [7:0]  data,
    output logic [15:0] crc
);

    logic preset;
    logic absorb;

    assign preset = (seg == SG_ID_SYNC) || (seg == SG_DT_SYNC);
    assign absorb = (seg == SG_ID_PFX)  || (seg == SG_ID_MARK) ||
                    (seg == SG_ID_BODY) || (seg == SG_DT_PFX)  ||
                    (seg == SG_DT_MARK) || (seg == SG_DT_BODY);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= 16'hFFFF;
        end else if (xfer) begin
            if (preset)      crc <= 16'hFFFF;
            else if (absorb) crc <= crc_step(crc, data);
        end
    end

endmodule

// File: rtl/trk_fmt_emit.sv
module trk_fmt_emit
    import trk_fmt_pkg::*;
(
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [7:0]       sec_idx,
    input  trk_cfg_t         cfg,
    input  logic [15:0]      crc,
    output logic [7:0]       byte_o,
    output logic             mark_o
);

    logic unused_emit;
    assign unused_emit = ^{cfg.nsec, cfg.gap3, cnt[CNT_W-1:2]};

    always_comb begin
        byte_o = 8'h00;
        mark_o = 1'b0;
        case (seg)
            SG_PRE_GAP, SG_POST_IX, SG_ID_GAP, SG_DT_GAP, SG_TAIL:
                byte_o = gap_byte(cfg.mfm);
            SG_IX_SYNC, SG_ID_SYNC, SG_DT_SYNC:
                byte_o = 8'h00;
            SG_IX_PFX: begin
                byte_o = 8'hC2;
                mark_o = 1'b1;
            end
            SG_ID_PFX, SG_DT_PFX: begin
                byte_o = 8'hA1;
                mark_o = 1'b1;
            end
            SG_IX_MARK: begin
                byte_o = 8'hFC;
                mark_o = !cfg.mfm;
            end
            SG_ID_MARK: begin
                byte_o = 8'hFE;
                mark_o = !cfg.mfm;
            end
            SG_DT_MARK: begin
                byte_o = cfg.del ? 8'hF8 : 8'hFB;
                mark_o = !cfg.mfm;
            end
            SG_ID_BODY: begin
                case (cnt[1:0])
                    2'd0:    byte_o = cfg.cyl;
                    2'd1:    byte_o = cfg.head;
                    2'd2:    byte_o = cfg.rec + sec_idx;
                    default: byte_o = 8'(cfg.size);
                endcase
            end
            SG_ID_CRC, SG_DT_CRC:
                byte_o = cnt[0] ? crc[7:0] : crc[15:8];
            SG_DT_BODY:
                byte_o = cfg.fill;
            default: begin
                byte_o = 8'h00;
                mark_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trk_fmt_seq.sv
module trk_fmt_seq
    import trk_fmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            stop,
    input  logic            mfm_sel,
    input  logic            del_data,
    input  logic [7:0]      sec_total,
    input  logic [SZ_W-1:0] size_code,
    input  logic [7:0]      gap3_len,
    input  logic [7:0]      fill_byte,
    input  logic [7:0]      id_cyl,
    input  logic [7:0]      id_head,
    input  logic [7:0]      id_rec,
    output logic [7:0]      out_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic            out_mark,
    output logic            busy
);

    trk_cfg_t         cfg_in;
    trk_cfg_t         cfg;
    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sec_idx;
    logic [15:0]      crc;
    logic             xfer;

    assign cfg_in = '{mfm:  mfm_sel,   del:  del_data,  nsec: sec_total,
                      size: size_code, gap3: gap3_len,  fill: fill_byte,
                      cyl:  id_cyl,    head: id_head,   rec:  id_rec};

    assign busy      = (seg != SG_IDLE);
    assign out_valid = busy;
    assign xfer      = out_valid && out_ready;

    trk_fmt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .xfer    (xfer),
        .cfg_in  (cfg_in),
        .seg     (seg),
        .cnt     (cnt),
        .sec_idx (sec_idx),
        .cfg     (cfg)
    );

    trk_fmt_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .xfer (xfer),
        .seg  (seg),
        .data (out_data),
        .crc  (crc)
    );

    trk_fmt_emit u_emit (
        .seg     (seg),
        .cnt     (cnt),
        .sec_idx (sec_idx),
        .cfg     (cfg),
        .crc     (crc),
        .byte_o  (out_data),
        .mark_o  (out_mark)
    );

endmodule

// File: rtl/trk_fmt_chk.sv
module trk_fmt_chk
    import trk_fmt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       stop,
    input logic       out_ready,
    input logic       out_valid,
    input logic       out_mark,
    input logic [7:0] out_data,
    input logic       busy,
    input seg_e       seg
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !out_valid));

    a_r2_start_begins: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && out_valid));

    a_r8_mark_values: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mark) |->
            (out_data == 8'hC2 || out_data == 8'hA1 || out_data == 8'hFC ||
             out_data == 8'hFE || out_data == 8'hFB || out_data == 8'hF8));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && seg != SG_TAIL) |=>
            (out_valid && $stable(out_data) && $stable(out_mark)));

    a_r11_tail_end: assert property (@(posedge clk) disable iff (rst)
        (seg == SG_TAIL && (start || stop)) |=> !busy);

endmodule

bind trk_fmt_seq trk_fmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_mark  (out_mark),
    .out_data  (out_data),
    .busy      (busy),
    .seg       (seg)
);

// File: tb/trk_fmt_seq_test.sv
module trk_fmt_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       mfm_sel = 1'b0;
    logic       del_data = 1'b0;
    logic [7:0] sec_total = 8'd0;
    logic [2:0] size_code = 3'd0;
    logic [7:0] gap3_len = 8'd1;
    logic [7:0] fill_byte = 8'd0;
    logic [7:0] id_cyl = 8'd0;
    logic [7:0] id_head = 8'd0;
    logic [7:0] id_rec = 8'd0;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_mark;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    trk_fmt_seq uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .mfm_sel(mfm_sel), .del_data(del_data), .sec_total(sec_total),
        .size_code(size_code), .gap3_len(gap3_len), .fill_byte(fill_byte),
        .id_cyl(id_cyl), .id_head(id_head), .id_rec(id_rec),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_mark(out_mark), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic put(input logic [7:0] b, input bit m, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({m, b});
            tag_q.push_back(t);
        end
    endtask

    task automatic build(input bit mfm, input bit del, input int nsec, input int size,
                         input int gap3, input logic [7:0] fill, input logic [7:0] c,
                         input logic [7:0] h, input logic [7:0] r);
        logic [7:0]  g;
        logic [15:0] crc;
        logic [7:0]  idb[4];
        int          gl;
        exp_q.delete();
        tag_q.delete();
        g = mfm ? 8'h4E : 8'hFF;
        if (mfm) begin
            put(g, 0, "R4", 80); put(8'h00, 0, "R4", 12);
            put(8'hC2, 1, "R4/R8", 3); put(8'hFC, 0, "R4/R8", 1);
            put(g, 0, "R4", 50);
        end else begin
            put(g, 0, "R3", 40); put(8'h00, 0, "R3", 6);
            put(8'hFC, 1, "R3/R8", 1); put(g, 0, "R3", 26);
        end
        for (int s = 0; s < nsec; s++) begin
            put(8'h00, 0, "R5", mfm ? 12 : 6);
            crc = 16'hFFFF;
            if (mfm) begin
                put(8'hA1, 1, "R5/R8", 3);
                for (int i = 0; i < 3; i++) crc = ref_crc(crc, 8'hA1);
            end
            put(8'hFE, !mfm, "R5/R8", 1);
            crc = ref_crc(crc, 8'hFE);
            idb[0] = c; idb[1] = h; idb[2] = r + 8'(s); idb[3] = 8'(size);
            for (int i = 0; i < 4; i++) begin
                put(idb[i], 0, (i == 2) ? "R12" : "R5", 1);
                crc = ref_crc(crc, idb[i]);
            end
            put(crc[15:8], 0, "R7", 1); put(crc[7:0], 0, "R7", 1);
            put(g, 0, "R5", mfm ? 22 : 11);
            put(8'h00, 0, "R6", mfm ? 12 : 6);
            crc = 16'hFFFF;
            if (mfm) begin
                put(8'hA1, 1, "R6/R8", 3);
                for (int i = 0; i < 3; i++) crc = ref_crc(crc, 8'hA1);
            end
            put(del ? 8'hF8 : 8'hFB, !mfm, "R6/R8", 1);
            crc = ref_crc(crc, del ? 8'hF8 : 8'hFB);
            put(fill, 0, "R6", 128 << size);
            for (int i = 0; i < (128 << size); i++) crc = ref_crc(crc, fill);
            put(crc[15:8], 0, "R7", 1); put(crc[7:0], 0, "R7", 1);
            gl = (gap3 == 0) ? 256 : gap3;
            put(g, 0, "R6", gl);
        end
        put(g, 0, (nsec == 0) ? "R10/R11" : "R11", 8);
    endtask

    task automatic run_track(input bit mfm, input bit del, input int nsec, input int size,
                             input int gap3, input logic [7:0] fill, input logic [7:0] c,
                             input logic [7:0] h, input logic [7:0] r, input bit rnd,
                             input bit poke, input bit end_start);
        int         idx;
        bit         hold;
        logic [7:0] pd;
        logic       pm;
        build(mfm, del, nsec, size, gap3, fill, c, h, r);
        mfm_sel = mfm; del_data = del; sec_total = 8'(nsec); size_code = 3'(size);
        gap3_len = 8'(gap3); fill_byte = fill; id_cyl = c; id_head = h; id_rec = r;
        out_ready = 1'b0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(out_valid && busy, "R2 valid after start", {out_valid, busy}, 3);
        // settings changed after start must not matter (R2)
        fill_byte = ~fill; id_cyl = ~c; mfm_sel = ~mfm;
        idx = 0; hold = 0; pd = 0; pm = 0;
        while (idx < exp_q.size()) begin
            out_ready = rnd ? ($urandom_range(3) != 0) : 1'b1;
            start = poke && (idx == 5);
            if (hold)
                chk(out_data == pd && out_mark == pm, "R9 hold", {out_mark, out_data}, {pm, pd});
            if (!out_valid) chk(0, "R2 valid during track", 0, 1);
            if (out_valid && out_ready) begin
                chk({out_mark, out_data} == exp_q[idx], tag_q[idx],
                    {out_mark, out_data}, exp_q[idx]);
                idx++;
                hold = 0;
            end else begin
                hold = out_valid; pd = out_data; pm = out_mark;
            end
            @(posedge clk); #1;
        end
        start = 1'b0;
        out_ready = 1'b1;
        if (end_start) start = 1'b1; else stop = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; stop = 1'b0;
        chk(!busy && !out_valid, "R11 end of track", {busy, out_valid}, 0);
        @(posedge clk); #1;
        chk(!busy, "R11 stays idle", busy, 0);
    endtask

    initial begin
        #(4 * 190000);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        void'($urandom(32'h1D5EED));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !out_valid, "R1 in reset", {busy, out_valid}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !out_valid, "R1 after reset", {busy, out_valid}, 0);

        // R3 FM index section plus one sector
        run_track(0, 0, 1, 0, 27, 8'hE5, 8'h02, 8'h00, 8'h01, 0, 0, 0);
        // R4 MFM, two sectors, deleted mark, sink stalls, mid-track start (R2)
        run_track(1, 1, 2, 1, 84, 8'h6D, 8'h27, 8'h01, 8'h05, 1, 1, 1);
        // R10 zero sectors, both modes
        run_track(0, 0, 0, 0, 10, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 1);
        run_track(1, 0, 0, 0, 10, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R6 GAP3 length 0 means 256
        run_track(1, 0, 1, 0, 0, 8'hAA, 8'h10, 8'h01, 8'h09, 0, 0, 0);
        // R12 record wraps past FF
        run_track(0, 1, 3, 0, 5, 8'h3C, 8'h4F, 8'h01, 8'hFE, 1, 0, 0);

        for (int t = 0; t < 6; t++) begin
            run_track($urandom_range(1), $urandom_range(1), $urandom_range(3),
                      $urandom_range(2), $urandom_range(40, 1), 8'($urandom),
                      8'($urandom), 8'($urandom), 8'($urandom), 1,
                      $urandom_range(1), $urandom_range(1));
        end
        finish_up();
    end

endmodule